// File: doc/BRIEF.md
# Energy-Window Pulse Counter

This block counts detector pulses whose peak lies inside an energy window. Two comparator flags come into the block. One says that the signal is above the lower threshold and the other says that it is above the upper threshold. A select input picks whether the flags come from the detector channel or from a test channel. The chosen pair passes through a synchronizer, and the block then tracks each pulse on the synchronized flags. A pulse becomes a candidate when the signal rises past the lower threshold. It is disqualified if the signal reaches the upper threshold at any point. It is counted once, when the signal falls back below the lower threshold.

Qualified pulses go into a binary counter, 18 bits wide by default. The counter does not wrap. When its top bit sets, that bit acts as a stop bit: the value freezes and the bit reads as an overrange flag. Software reads the count as bytes through a small read-only address space, and a synchronous clear starts a new measurement.

Top module: `win_disc_counter`

## Requirements
- R1: `src_sel`=0 takes the flags from `det_lo`/`det_hi` and `src_sel`=1 takes them from `tst_lo`/`tst_hi`. Pulses on the channel that is not selected leave the count unchanged.
- R2: A candidate pulse adds exactly one to the count, and only after the lower flag returns low. While the lower flag stays high, no count is added. The new value can be read at most four cycles after the lower flag is driven low.
- R3: If the upper flag is high in any cycle while the lower flag is high, that pulse is not counted. This holds when the upper flag rises together with the lower flag, and when the upper flag drops again before the lower flag does.
- R4: The count is a plain binary count that goes up by one for each qualified pulse, including back-to-back pulses with the lower flag high for one cycle and low for one cycle.
- R5: Read address 0 returns count bits 7:0 and address 1 returns bits 15:8. Address 3 returns bits 17:16 in data bits 1:0, with data bits 7:2 zero.
- R6: The count's most significant bit is a stop bit. Once it is set, no further pulse changes the count until a clear, and the bit reads as the overrange flag (bit 1 at address 3 for the default width).
- R7: `clr`=1 at a rising edge zeroes the count, the stop bit and any candidate pulse. A count event in the same cycle as the clear is dropped.
- R8: Read address 2 returns zero.
- R9: After `rst_n` is released, all addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of count and pulse state |
| src_sel | input | 1 | Channel select: 0 detector, 1 test |
| det_lo | input | 1 | Detector channel, above lower threshold |
| det_hi | input | 1 | Detector channel, above upper threshold |
| tst_lo | input | 1 | Test channel, above lower threshold |
| tst_hi | input | 1 | Test channel, above upper threshold |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data for `rd_addr` (combinational) |

## Verification
The main function is tried with the following patterns:
- **Slow in-window pulses.** These show that the count moves on the falling edge of the lower flag and not on its rising edge.
- **Over-window pulses, with the upper flag rising together with the lower flag or later.** These separate a veto that clears the candidate from one that only blocks a count while the upper flag is high.
- **A long burst of one-cycle pulses.** This drives the count across byte boundaries and into bit 16, which checks the byte map.
- **The same burst on a narrow-counter instance.** This shows that the count freezes at the stop bit instead of wrapping.
- **Test-channel pulses with each select value.** These separate the two sources.
- **A clear timed into the cycle of a pending count event.** This checks that the clear takes priority.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
   localparam int unsigned DATA_W  = 8;
   localparam int unsigned ADDR_W  = 2;
   localparam int unsigned SPACE_W = 24;

   localparam logic [ADDR_W-1:0] RA_BYTE0 = 2'd0;
   localparam logic [ADDR_W-1:0] RA_BYTE1 = 2'd1;
   localparam logic [ADDR_W-1:0] RA_GAP   = 2'd2;
   localparam logic [ADDR_W-1:0] RA_BYTE2 = 2'd3;

   typedef struct packed {
      logic hi;
      logic lo;
   } flags_t;
endpackage

// File: rtl/wdc_sync.sv
module wdc_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/wdc_disc.sv
module wdc_disc (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lo_s,
   input  logic hi_s,
   output logic cnt_ev
);
   logic lo_d;
   logic armed;
   logic rise_lo;
   logic fall_lo;

   assign rise_lo = lo_s & ~lo_d;
   assign fall_lo = ~lo_s & lo_d;
   assign cnt_ev  = fall_lo & armed & ~hi_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_d  <= 1'b0;
         armed <= 1'b0;
      end else begin
         lo_d <= lo_s;
         if (clr || hi_s || fall_lo) armed <= 1'b0;
         else if (rise_lo)           armed <= 1'b1;
      end
   end

   AST_VETO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hi_s |=> !armed); // R3
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ev |=> !cnt_ev); // R2
endmodule

// File: rtl/wdc_counter.sv
module wdc_counter #(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam int unsigned STOP_IDX = W - 1;

   logic stop;
   assign stop = cnt[STOP_IDX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr)          cnt <= '0;
      else if (inc && !stop) cnt <= cnt + 1'b1;
   end

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R4
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[STOP_IDX] && !clr) |=> $stable(cnt)); // R6
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0); // R7
endmodule

// File: rtl/wdc_regs.sv
module wdc_regs
   import wdc_pkg::*;
#(
   parameter int unsigned CNT_W = 18
) (
   input  logic [CNT_W-1:0]  cnt,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned PAD_W = SPACE_W - CNT_W;

   logic [SPACE_W-1:0] wide;

   generate
      if (PAD_W == 0) begin : g_full
         assign wide = cnt;
      end else begin : g_pad
         assign wide = {{PAD_W{1'b0}}, cnt};
      end
   endgenerate

   always_comb begin
      unique case (rd_addr)
         RA_BYTE0: rd_data = wide[7:0];
         RA_BYTE1: rd_data = wide[15:8];
         RA_BYTE2: rd_data = wide[23:16];
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/win_disc_counter.sv
module win_disc_counter
   import wdc_pkg::*;
#(
   parameter int unsigned CNT_W       = 18,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              src_sel,
   input  logic              det_lo,
   input  logic              det_hi,
   input  logic              tst_lo,
   input  logic              tst_hi,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (CNT_W < 9 || CNT_W > SPACE_W) begin : g_bad_width
         $error("win_disc_counter: CNT_W out of range");
      end
   endgenerate

   flags_t            raw_f;
   flags_t            syn_f;
   logic              cnt_ev;
   logic [CNT_W-1:0]  cnt;

   assign raw_f.lo = src_sel ? tst_lo : det_lo;
   assign raw_f.hi = src_sel ? tst_hi : det_hi;

   wdc_sync #(.STAGES(SYNC_STAGES), .W(2)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw_f), .q(syn_f)
   );

   wdc_disc disc_i (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .lo_s(syn_f.lo), .hi_s(syn_f.hi), .cnt_ev(cnt_ev)
   );

   wdc_counter #(.W(CNT_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(cnt_ev), .cnt(cnt)
   );

   wdc_regs #(.CNT_W(CNT_W)) regs_i (
      .cnt(cnt), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   AST_NO_COUNT_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (syn_f.lo && !clr) |=> $stable(cnt)); // R2
endmodule

// File: tb/win_disc_counter_tb_top.sv
module win_disc_counter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       src_sel = 1'b0;
   logic       det_lo = 1'b0, det_hi = 1'b0, tst_lo = 1'b0, tst_hi = 1'b0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data, rd_data_n;

   int n_chk = 0;
   int n_bad = 0;
   int exp_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   win_disc_counter dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .src_sel(src_sel),
      .det_lo(det_lo), .det_hi(det_hi), .tst_lo(tst_lo), .tst_hi(tst_hi),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   win_disc_counter #(.CNT_W(10)) dut_narrow_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .src_sel(src_sel),
      .det_lo(det_lo), .det_hi(det_hi), .tst_lo(tst_lo), .tst_hi(tst_hi),
      .rd_addr(rd_addr), .rd_data(rd_data_n)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic [7:0] dn);
      @(negedge clk);
      rd_addr = a;
      #1;
      d  = rd_data;
      dn = rd_data_n;
   endtask

   task automatic read_cnt(output int c, output int cn);
      logic [7:0] b0, b1, b3, n0, n1, n3;
      rd(2'd0, b0, n0);
      rd(2'd1, b1, n1);
      rd(2'd3, b3, n3);
      c  = {b3, b1, b0};
      cn = {n3, n1, n0};
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_lo(input logic tst, input logic v);
      if (tst) tst_lo = v; else det_lo = v;
   endtask

   task automatic set_hi(input logic tst, input logic v);
      if (tst) tst_hi = v; else det_hi = v;
   endtask

   task automatic slow_pulse(input logic tst, input int width);
      @(negedge clk); set_lo(tst, 1'b1);
      idle(width);
      set_lo(tst, 1'b0);
      idle(6);
   endtask

   task automatic test_reset();
      int c, cn;
      logic [7:0] d, dn;
      read_cnt(c, cn);
      check("R9 count after reset", c, 0);
      rd(2'd2, d, dn);
      check("R8 gap address after reset", d, 0);
   endtask

   task automatic test_in_window();
      int c, cn;
      @(negedge clk); det_lo = 1'b1;
      idle(8);
      read_cnt(c, cn);
      check("R2 no count while lower flag high", c, exp_cnt);
      det_lo = 1'b0;
      idle(4);
      exp_cnt++;
      read_cnt(c, cn);
      check("R2 single count on return below lower", c, exp_cnt);
   endtask

   task automatic test_veto();
      int c, cn;
      @(negedge clk); det_lo = 1'b1;
      idle(2); det_hi = 1'b1;
      idle(1); det_hi = 1'b0;
      idle(3); det_lo = 1'b0;
      idle(6);
      read_cnt(c, cn);
      check("R3 veto, upper drops before lower", c, exp_cnt);
      @(negedge clk); det_lo = 1'b1; det_hi = 1'b1;
      idle(3); det_hi = 1'b0;
      idle(3); det_lo = 1'b0;
      idle(6);
      read_cnt(c, cn);
      check("R3 veto, upper rises with lower", c, exp_cnt);
   endtask

   task automatic test_multi();
      int c, cn;
      for (int i = 0; i < 5; i++) slow_pulse(1'b0, 2 + i);
      exp_cnt += 5;
      read_cnt(c, cn);
      check("R4 five in-window pulses", c, exp_cnt);
   endtask

   task automatic test_source();
      int c, cn;
      src_sel = 1'b0;
      slow_pulse(1'b1, 3);
      read_cnt(c, cn);
      check("R1 test channel ignored with src_sel=0", c, exp_cnt);
      src_sel = 1'b1;
      idle(4);
      slow_pulse(1'b0, 3);
      read_cnt(c, cn);
      check("R1 detector channel ignored with src_sel=1", c, exp_cnt);
      slow_pulse(1'b1, 3);
      exp_cnt++;
      read_cnt(c, cn);
      check("R1 test channel counted with src_sel=1", c, exp_cnt);
      src_sel = 1'b0;
      idle(4);
   endtask

   task automatic burst(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); det_lo = 1'b1;
         @(negedge clk); det_lo = 1'b0;
      end
      idle(6);
   endtask

   task automatic test_overrange_and_map();
      int c, cn;
      logic [7:0] d, dn;
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      burst(520);
      read_cnt(c, cn);
      check("R4 burst of 520 one-cycle pulses", c, 520);
      check("R6 narrow counter frozen at stop bit", cn, 512);
      rd(2'd1, d, dn);
      check("R6 narrow stop bit readable", dn, 8'h02);
      burst(65539 - 520);
      rd(2'd0, d, dn);
      check("R5 address 0 low byte", d, 8'h03);
      rd(2'd1, d, dn);
      check("R5 address 1 middle byte", d, 8'h00);
      rd(2'd3, d, dn);
      check("R5 address 3 top bits", d, 8'h01);
      check("R6 narrow counter still frozen", dn, 8'h00);
      rd(2'd2, d, dn);
      check("R8 gap address with nonzero count", d, 0);
   endtask

   task automatic test_clear();
      int c, cn;
      @(negedge clk); det_lo = 1'b1;
      idle(4);
      det_lo = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      idle(6);
      read_cnt(c, cn);
      check("R7 count event during clear dropped", c, 0);
      check("R7 narrow counter cleared", cn, 0);
      @(negedge clk); det_lo = 1'b1;
      idle(3);
      clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      det_lo = 1'b0;
      idle(6);
      read_cnt(c, cn);
      check("R7 clear discards armed pulse", c, 0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      test_reset();
      test_in_window();
      test_veto();
      test_multi();
      test_source();
      test_overrange_and_map();
      test_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * WD_CYCLES);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule